// File: doc/BRIEF.md
# Paired-Half Floating-Point Register File

This block stores the floating-point register state as sixteen 64-bit entries. Each entry pairs two single-precision registers. The even register of the pair sits in the upper 32 bits and the odd register sits in the lower 32 bits. A 5-bit register number selects its entry through its upper four bits, and its lowest bit picks the half. Each half has its own write enable, so a single-precision result touches one half and a double-precision result touches both.

Write data passes through a data-in register first. Each cycle, every half of that register either loads the selected source or keeps its value, under a per-half hold bit. The source is memory load data or an FPU result. On a write edge, the contents of the data-in register go into the addressed entry.

There are three read ports, all combinational: two operand ports and a store port. Each port has a per-half bypass select, which chooses either the array contents or the data-in register contents, so a write in flight reaches a matching read in the same cycle. The two operand ports also have an alignment select that lifts an odd single-precision value into the upper half. Generating the control inputs and formatting store data are left to neighbouring logic.

Top module: `fprf_pair_bank`

## Requirements
- R1: An active-low reset clears every entry and the data-in register to zero.
- R2: At each rising edge, a half of the data-in register whose hold bit is 0 loads the matching half of the selected source. The source is `load_data` when `src_sel` is 0 and `result_data` when `src_sel` is 1.
- R3: A half of the data-in register whose hold bit is 1 keeps its value. `hold_din[0]` controls bits 31:0 and `hold_din[1]` controls bits 63:32.
- R4: At a rising edge, `wr_en[1]` writes data-in bits 63:32 into bits 63:32 of entry `wr_addr`, and `wr_en[0]` writes data-in bits 31:0 into bits 31:0 of that entry.
- R5: A write with one enable bit set leaves the other half of the entry, and every other entry, unchanged.
- R6: Each read port returns the addressed entry in the same cycle, with no clock edge in between.
- R7: Each bypass control is two one-hot groups: bits 2:0 for the low half and bits 5:3 for the high half. Within a group, the lowest bit selects array data and the highest bit selects the data-in register. The middle bit is unused and is held at 0. The data-in register is selected only when that half is being written to the port's address.
- R8: The operand-port alignment code 2'b01 passes the word through unchanged. The code 2'b10 places bits 31:0 in bits 63:32 and drives zeros in bits 31:0. Alignment is applied after bypass.
- R9: The store port (port 3) has no alignment and always returns the bypassed 64-bit word as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_sel | input | 1 | Write source: 0 load data, 1 FPU result |
| load_data | input | 64 | Load data from memory |
| result_data | input | 64 | FPU result data |
| hold_din | input | 2 | Per-half hold for the data-in register (bit 0 low, bit 1 high) |
| wr_addr | input | 4 | Entry written |
| wr_en | input | 2 | Half write enables (bit 0 low/odd, bit 1 high/even) |
| rd_addr1 | input | 4 | Operand port 1 entry |
| rd_addr2 | input | 4 | Operand port 2 entry |
| rd_addr3 | input | 4 | Store port entry |
| algn1 | input | 2 | Port 1 alignment code |
| algn2 | input | 2 | Port 2 alignment code |
| byp1 | input | 6 | Port 1 bypass groups |
| byp2 | input | 6 | Port 2 bypass groups |
| byp3 | input | 6 | Port 3 bypass groups |
| rd_data1 | output | 64 | Port 1 read data |
| rd_data2 | output | 64 | Port 2 read data |
| rd_data3 | output | 64 | Port 3 read data |

## Verification
All three read results follow their address, bypass and alignment inputs with zero delay. The bench drives inputs after the falling edge and compares the ports one time unit later, in the same cycle. A source capture appears in the data-in register one edge later, and it reaches a port either that cycle through bypass or after a second edge through the array. The bench's reference model therefore updates only after each rising edge: it applies array writes using the old data-in value, then updates the data-in register. The next comparison is made against this updated state.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
   // halves of one entry
   localparam int HALVES   = 2;
   localparam int HALF_LO  = 0;
   localparam int HALF_HI  = 1;
   // one bypass group per half
   localparam int GRP_W    = 3;
   localparam int SEL_ARR  = 0;
   localparam int SEL_WR   = 2;
   // alignment code bits
   localparam int ALG_PASS = 0;
   localparam int ALG_ODD  = 1;
endpackage

// File: rtl/fprf_din_reg.sv
module fprf_din_reg
   import fprf_pkg::*;
#(
   parameter int HALF_W = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       src_sel,
   input  logic [HALVES*HALF_W-1:0]   load_data,
   input  logic [HALVES*HALF_W-1:0]   result_data,
   input  logic [HALVES-1:0]          hold,
   output logic [HALVES*HALF_W-1:0]   din_q
);
   for (genvar h = 0; h < HALVES; h++) begin : g_half
      logic [HALF_W-1:0] q;
      logic [HALF_W-1:0] nxt;
      assign nxt = src_sel ? result_data[h*HALF_W +: HALF_W]
                           : load_data[h*HALF_W +: HALF_W];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (!hold[h])
            q <= nxt;
      end
      assign din_q[h*HALF_W +: HALF_W] = q;
   end
endmodule

// File: rtl/fprf_array.sv
module fprf_array
   import fprf_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int HALF_W  = 32,
   parameter int NRD     = 3,
   localparam int AW     = $clog2(ENTRIES),
   localparam int WW     = HALVES*HALF_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [AW-1:0]       wr_addr,
   input  logic [HALVES-1:0]   wr_en,
   input  logic [WW-1:0]       wr_word,
   input  logic [NRD*AW-1:0]   rd_addr,
   output logic [NRD*WW-1:0]   rd_word
);
   if (ENTRIES != (1 << AW)) begin : g_bad_depth
      $error("fprf_array: ENTRIES must be a power of two");
   end
   if (NRD < 1) begin : g_bad_ports
      $error("fprf_array: NRD must be at least one");
   end

   for (genvar h = 0; h < HALVES; h++) begin : g_half
      logic [HALF_W-1:0] mem [ENTRIES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++)
               mem[i] <= '0;
         end else if (wr_en[h]) begin
            mem[wr_addr] <= wr_word[h*HALF_W +: HALF_W];
         end
      end
      for (genvar p = 0; p < NRD; p++) begin : g_rd
         assign rd_word[p*WW + h*HALF_W +: HALF_W] = mem[rd_addr[p*AW +: AW]];
      end
   end
endmodule

// File: rtl/fprf_read_port.sv
module fprf_read_port
   import fprf_pkg::*;
#(
   parameter int HALF_W    = 32,
   parameter bit HAS_ALIGN = 1'b1,
   localparam int WW       = HALVES*HALF_W
) (
   input  logic [WW-1:0]             arr_word,
   input  logic [WW-1:0]             wr_word,
   input  logic [HALVES*GRP_W-1:0]   byp,
   input  logic [1:0]                algn,
   output logic [WW-1:0]             dout
);
   logic [WW-1:0] merged;
   logic [HALVES-1:0] unused_mid;

   for (genvar h = 0; h < HALVES; h++) begin : g_half
      logic [GRP_W-1:0] grp;
      assign grp = byp[h*GRP_W +: GRP_W];
      assign merged[h*HALF_W +: HALF_W] =
           ({HALF_W{grp[SEL_ARR]}} & arr_word[h*HALF_W +: HALF_W])
         | ({HALF_W{grp[SEL_WR]}}  & wr_word[h*HALF_W +: HALF_W]);
      assign unused_mid[h] = grp[1];
   end

   if (HAS_ALIGN) begin : g_align
      logic [WW-1:0] lifted;
      assign lifted = {merged[HALF_LO*HALF_W +: HALF_W], {HALF_W{1'b0}}};
      assign dout   = ({WW{algn[ALG_PASS]}} & merged)
                    | ({WW{algn[ALG_ODD]}}  & lifted);
   end else begin : g_plain
      logic [1:0] unused_algn;
      assign unused_algn = algn;
      assign dout = merged;
   end
endmodule

// File: rtl/fprf_pair_bank.sv
module fprf_pair_bank
   import fprf_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int HALF_W  = 32,
   localparam int AW     = $clog2(ENTRIES),
   localparam int WW     = HALVES*HALF_W,
   localparam int NRD    = 3,
   localparam int NALG   = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          src_sel,
   input  logic [WW-1:0] load_data,
   input  logic [WW-1:0] result_data,
   input  logic [1:0]    hold_din,
   input  logic [AW-1:0] wr_addr,
   input  logic [1:0]    wr_en,
   input  logic [AW-1:0] rd_addr1,
   input  logic [AW-1:0] rd_addr2,
   input  logic [AW-1:0] rd_addr3,
   input  logic [1:0]    algn1,
   input  logic [1:0]    algn2,
   input  logic [5:0]    byp1,
   input  logic [5:0]    byp2,
   input  logic [5:0]    byp3,
   output logic [WW-1:0] rd_data1,
   output logic [WW-1:0] rd_data2,
   output logic [WW-1:0] rd_data3
);
   if (HALF_W < 1) begin : g_bad_width
      $error("fprf_pair_bank: HALF_W must be positive");
   end

   logic [WW-1:0]          din_q;
   logic [NRD*AW-1:0]      rd_addr_v;
   logic [NRD*WW-1:0]      arr_v;
   logic [NRD*WW-1:0]      out_v;
   logic [NRD*6-1:0]       byp_v;
   logic [NRD*2-1:0]       algn_v;

   assign rd_addr_v = {rd_addr3, rd_addr2, rd_addr1};
   assign byp_v     = {byp3, byp2, byp1};
   // store port has no alignment; its code is tied to pass
   assign algn_v    = {2'b01, algn2, algn1};

   fprf_din_reg #(.HALF_W(HALF_W)) u_din (
      .clk         (clk),
      .rst_n       (rst_n),
      .src_sel     (src_sel),
      .load_data   (load_data),
      .result_data (result_data),
      .hold        (hold_din),
      .din_q       (din_q)
   );

   fprf_array #(.ENTRIES(ENTRIES), .HALF_W(HALF_W), .NRD(NRD)) u_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_addr (wr_addr),
      .wr_en   (wr_en),
      .wr_word (din_q),
      .rd_addr (rd_addr_v),
      .rd_word (arr_v)
   );

   for (genvar p = 0; p < NRD; p++) begin : g_port
      fprf_read_port #(.HALF_W(HALF_W), .HAS_ALIGN(p < NALG)) u_port (
         .arr_word (arr_v[p*WW +: WW]),
         .wr_word  (din_q),
         .byp      (byp_v[p*6 +: 6]),
         .algn     (algn_v[p*2 +: 2]),
         .dout     (out_v[p*WW +: WW])
      );
   end

   assign rd_data1 = out_v[0*WW +: WW];
   assign rd_data2 = out_v[1*WW +: WW];
   assign rd_data3 = out_v[2*WW +: WW];
endmodule

// File: rtl/fprf_pair_bank_chk.sv
module fprf_pair_bank_chk #(
   parameter int HALF_W = 32,
   parameter int AW     = 4,
   localparam int WW    = 2*HALF_W
) (
   input logic          clk,
   input logic          rst_n,
   input logic          src_sel,
   input logic [WW-1:0] load_data,
   input logic [1:0]    hold_din,
   input logic [AW-1:0] wr_addr,
   input logic [1:0]    wr_en,
   input logic [AW-1:0] rd_addr1,
   input logic [AW-1:0] rd_addr3,
   input logic [1:0]    algn1,
   input logic [1:0]    algn2,
   input logic [5:0]    byp1,
   input logic [5:0]    byp2,
   input logic [5:0]    byp3,
   input logic [WW-1:0] rd_data1,
   input logic [WW-1:0] rd_data2,
   input logic [WW-1:0] rd_data3,
   input logic [WW-1:0] din_q
);
   // R7: each half group picks exactly one source, middle bit idle
   p_byp_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({byp1[2], byp1[0]}) && $onehot({byp1[5], byp1[3]}) &&
      $onehot({byp2[2], byp2[0]}) && $onehot({byp2[5], byp2[3]}) &&
      $onehot({byp3[2], byp3[0]}) && $onehot({byp3[5], byp3[3]}) &&
      !byp1[1] && !byp1[4] && !byp2[1] && !byp2[4] && !byp3[1] && !byp3[4]);

   // R7: forwarding only for a matching write of that half
   p_byp_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      byp1[2] |-> (wr_en[0] && wr_addr == rd_addr1));

   // R7: forwarded high half on port 2 carries the data-in register
   p_fwd_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (byp2[5] && algn2 == 2'b01) |-> rd_data2[WW-1:HALF_W] == din_q[WW-1:HALF_W]);

   // R8: alignment codes are one-hot
   p_algn_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(algn1) && $onehot(algn2));

   // R8: odd-single alignment zeroes the low half
   p_odd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      algn1[1] |-> rd_data1[HALF_W-1:0] == '0);

   // R3: a held low half keeps its value
   p_hold_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hold_din[0] |=> din_q[HALF_W-1:0] == $past(din_q[HALF_W-1:0]));

   // R2: an open high half loads the memory data when selected
   p_capture_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_din[1] && !src_sel) |=> din_q[WW-1:HALF_W] == $past(load_data[WW-1:HALF_W]));

   // R4: a high-half write is visible through the store port array path
   p_write_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[1] |=> ((rd_addr3 == $past(wr_addr) && byp3[3])
                    -> rd_data3[WW-1:HALF_W] == $past(din_q[WW-1:HALF_W])));
endmodule

bind fprf_pair_bank fprf_pair_bank_chk #(.HALF_W(HALF_W), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_sel   (src_sel),
   .load_data (load_data),
   .hold_din  (hold_din),
   .wr_addr   (wr_addr),
   .wr_en     (wr_en),
   .rd_addr1  (rd_addr1),
   .rd_addr3  (rd_addr3),
   .algn1     (algn1),
   .algn2     (algn2),
   .byp1      (byp1),
   .byp2      (byp2),
   .byp3      (byp3),
   .rd_data1  (rd_data1),
   .rd_data2  (rd_data2),
   .rd_data3  (rd_data3),
   .din_q     (din_q)
);

// File: tb/fprf_pair_bank_tb.sv
module fprf_pair_bank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        src_sel = 1'b0;
   logic [63:0] load_data = '0;
   logic [63:0] result_data = '0;
   logic [1:0]  hold_din = 2'b00;
   logic [3:0]  wr_addr = '0;
   logic [1:0]  wr_en = 2'b00;
   logic [3:0]  rd_addr1 = '0, rd_addr2 = '0, rd_addr3 = '0;
   logic [1:0]  algn1 = 2'b01, algn2 = 2'b01;
   logic [5:0]  byp1 = 6'b001001, byp2 = 6'b001001, byp3 = 6'b001001;
   logic [63:0] rd_data1, rd_data2, rd_data3;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit fwd_always = 1'b1;
   string cur_tag = "R6";

   // reference state
   logic [63:0] m_mem [16];
   logic [63:0] m_din;

   always #4 clk = ~clk;

   fprf_pair_bank u_dut (
      .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
      .load_data(load_data), .result_data(result_data), .hold_din(hold_din),
      .wr_addr(wr_addr), .wr_en(wr_en),
      .rd_addr1(rd_addr1), .rd_addr2(rd_addr2), .rd_addr3(rd_addr3),
      .algn1(algn1), .algn2(algn2),
      .byp1(byp1), .byp2(byp2), .byp3(byp3),
      .rd_data1(rd_data1), .rd_data2(rd_data2), .rd_data3(rd_data3)
   );

   task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // legal bypass choice for one port
   function automatic logic [5:0] pick_byp(logic [3:0] ra, bit always_fwd);
      logic [5:0] b;
      for (int h = 0; h < 2; h++) begin
         bit fwd;
         fwd = wr_en[h] && (ra == wr_addr) && (always_fwd || $urandom_range(1) == 1);
         b[h*3 +: 3] = fwd ? 3'b100 : 3'b001;
      end
      return b;
   endfunction

   function automatic logic [63:0] model_port(logic [3:0] ra, logic [5:0] b,
                                              logic [1:0] al);
      logic [31:0] hi, lo;
      hi = b[5] ? m_din[63:32] : m_mem[ra][63:32];
      lo = b[2] ? m_din[31:0]  : m_mem[ra][31:0];
      if (al == 2'b10) return {lo, 32'h0};
      return {hi, lo};
   endfunction

   // called just after a falling edge with inputs already set
   task automatic cyc();
      byp1 = pick_byp(rd_addr1, fwd_always);
      byp2 = pick_byp(rd_addr2, fwd_always);
      byp3 = pick_byp(rd_addr3, fwd_always);
      #1;
      check64({cur_tag, " port1"}, rd_data1, model_port(rd_addr1, byp1, algn1));
      check64({cur_tag, " port2"}, rd_data2, model_port(rd_addr2, byp2, algn2));
      check64({cur_tag, " port3 R9"}, rd_data3, model_port(rd_addr3, byp3, 2'b01));
      @(posedge clk);
      #1;
      // array first (uses old data-in), then data-in
      if (wr_en[1]) m_mem[wr_addr][63:32] = m_din[63:32];
      if (wr_en[0]) m_mem[wr_addr][31:0]  = m_din[31:0];
      if (!hold_din[1]) m_din[63:32] = src_sel ? result_data[63:32] : load_data[63:32];
      if (!hold_din[0]) m_din[31:0]  = src_sel ? result_data[31:0]  : load_data[31:0];
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R6 actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) m_mem[i] = '0;
      m_din = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: every entry reads zero after reset
      for (int i = 0; i < 16; i++) begin
         rd_addr1 = 4'(i);
         #1;
         check64("R1 reset entry", rd_data1, 64'h0);
      end
      @(negedge clk);

      // R2: capture load data
      cur_tag = "R2";
      src_sel = 1'b0; load_data = 64'hAAAA_1111_BBBB_2222; hold_din = 2'b00;
      cyc();
      // R4: write both halves of entry 5, read with forwarding
      cur_tag = "R4";
      wr_en = 2'b11; wr_addr = 4'd5; rd_addr1 = 4'd5; rd_addr2 = 4'd5; rd_addr3 = 4'd5;
      src_sel = 1'b1; result_data = 64'hCCCC_3333_DDDD_4444;
      cyc();
      wr_en = 2'b00;
      byp3 = 6'b001001; #1;
      check64("R4 entry 5 literal", rd_data3, 64'hAAAA_1111_BBBB_2222);
      // R3: hold low half while high half loads new data
      cur_tag = "R3";
      hold_din = 2'b01; src_sel = 1'b0; load_data = 64'h5555_6666_7777_8888;
      cyc();
      hold_din = 2'b11; wr_en = 2'b11; wr_addr = 4'd6; rd_addr3 = 4'd6;
      cyc();
      wr_en = 2'b00; byp3 = 6'b001001; #1;
      check64("R3 held half literal", rd_data3, 64'h5555_6666_DDDD_4444);
      // R5: low-only write keeps the high half of entry 5
      cur_tag = "R5";
      wr_en = 2'b01; wr_addr = 4'd5; rd_addr3 = 4'd5;
      cyc();
      wr_en = 2'b00; byp3 = 6'b001001; #1;
      check64("R5 high half kept", rd_data3, 64'hAAAA_1111_DDDD_4444);
      // R8: odd-single alignment on both operand ports
      cur_tag = "R8";
      algn1 = 2'b10; algn2 = 2'b10; rd_addr1 = 4'd6; rd_addr2 = 4'd5;
      cyc();
      #1;
      check64("R8 odd lift literal", rd_data1, 64'hDDDD_4444_0000_0000);

      // R6/R7: random traffic with frequent collisions
      hold_din = 2'b00;
      for (int n = 0; n < 3000; n++) begin
         fwd_always = (n % 3 != 0);
         cur_tag = fwd_always ? "R7" : "R6";
         src_sel     = 1'($urandom_range(1));
         load_data   = {$urandom, $urandom};
         result_data = {$urandom, $urandom};
         hold_din    = 2'($urandom_range(3));
         wr_addr     = 4'($urandom_range(15));
         wr_en       = 2'($urandom_range(3));
         rd_addr1    = ($urandom_range(1) == 1) ? wr_addr : 4'($urandom_range(15));
         rd_addr2    = ($urandom_range(1) == 1) ? wr_addr : 4'($urandom_range(15));
         rd_addr3    = ($urandom_range(1) == 1) ? wr_addr : 4'($urandom_range(15));
         algn1       = ($urandom_range(1) == 1) ? 2'b10 : 2'b01;
         algn2       = ($urandom_range(1) == 1) ? 2'b10 : 2'b01;
         cyc();
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule